// File: doc/BRIEF.md
# Modified Miller Frame Decoder

This block turns the raw, oversampled carrier-pause stream sent from a reader to a card into bytes. Every accepted input beat holds eight line samples, oldest first, where a sample of 0 means the carrier is paused. While idle the decoder hunts for the start pattern. Once it finds one, it locks to that bit-period phase and classifies each following period by where its pause falls. It enforces the legal orderings between period kinds, assembles nine-bit characters, and emits data bytes on one stream and packed parity bits on a second stream. When it sees the closing sequence it raises a frame-done flag together with start and end timestamps counted in samples.

Input beats arrive on a valid/ready stream. Both output streams are valid/ready with a one-entry holding register each. A beat is only accepted while both holding registers are empty or being drained in the same cycle. Back-pressure on either output therefore stalls the input rather than dropping data. The host pulses the synchronous reset between frames. After a completed frame the decoder ignores further beats until that reset.

Top module: `miller_frame_decoder`

## Requirements
- R1: After reset, in_ready is 1, byte_valid and par_valid are 0, frame_done is 0 and byte_count is 0.
- R2: A half period (four samples) counts as paused when at least two of its samples are 0; a half with one or no 0 sample counts as unpaused. Sample bit i of in_samples is the i-th in time.
- R3: While hunting, the first eight-sample period reading 0,0,any,1,1,1,1,1 in time order starts a frame. start_ts is the index of that period's first sample, counting accepted samples from 0 after reset.
- R4: Periods decode as Z (pause in first half only) = 0, X (pause in second half only) = 1, and Y (no pause) after an X = 0. Every nine decoded bits form a character: the first eight bits are emitted as a byte, LSB first. byte_count increments once per byte.
- R5: The ninth bit of each character enters the parity stream. Parity bytes fill from MSB to LSB, and one is emitted after every eight characters.
- R6: A period paused in both halves, a Z right after an X, or a Y right after the start pattern aborts the frame. byte_count returns to 0 and hunting resumes, so a later start pattern begins a new frame.
- R7: A Y following a Z or a Y ends the frame, and the bits of any unfinished character are dropped. If at least one byte was emitted, frame_done rises and any leftover parity bits are emitted left-aligned in one final parity byte. If no byte was emitted, the decoder returns to hunting with frame_done left at 0.
- R8: On every X or Z, end_ts becomes start_ts + 8*n + 6 (X) or start_ts + 8*n + 2 (Z), where n counts the bits decoded so far in the frame including this one. A Y decoded as 0 leaves end_ts unchanged.
- R9: While an output holds an item that is not taken, in_ready is 0 and the held value stays stable. No byte or parity item is lost or duplicated under back-pressure.
- R10: While frame_done is 1, accepted beats change neither byte_count, start_ts nor the output streams.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_samples | input | 8 | Line samples, bit 0 oldest, 0 = pause |
| byte_valid | output | 1 | Data byte valid |
| byte_ready | input | 1 | Data byte taken |
| byte_data | output | 8 | Decoded data byte |
| par_valid | output | 1 | Parity byte valid |
| par_ready | input | 1 | Parity byte taken |
| par_data | output | 8 | Packed parity bits, first at MSB |
| frame_done | output | 1 | Frame completed, held until reset |
| byte_count | output | CNT_W | Bytes decoded in current frame |
| start_ts | output | TS_W | Sample index of frame start |
| end_ts | output | TS_W | Sample-based end time of last pause |

## Verification
A wrong locked phase or a wrong period class shows within one beat, either as a spurious abort (byte_count falling to 0) or as a corrupted byte at the next character boundary nine periods later. An ordering-state fault shows as a missing or premature frame_done at the closing sequence, and a bit-counter fault shifts every following byte and parity item. Timestamp faults appear directly on start_ts after lock and on end_ts after the last X or Z. The bench compares every streamed item against a model queue under random back-pressure, so a lost or repeated item is exposed at once.

// File: rtl/miller_pkg.sv
package miller_pkg;
  localparam int BEAT   = 8;
  localparam int HALF   = BEAT / 2;
  localparam int WIN    = 2 * BEAT;
  localparam int POS_W  = $clog2(BEAT);
  localparam int CHAR_W = 9;
  localparam int BIT_W  = $clog2(CHAR_W + 1);
  localparam int PAR_W  = 8;
  localparam int PCNT_W = $clog2(PAR_W);

  typedef enum logic [1:0] {SEQ_Y, SEQ_X, SEQ_Z, SEQ_BAD} seq_e;
  typedef enum logic [2:0] {ST_HUNT, ST_SOC, ST_X, ST_Y, ST_Z, ST_DONE} st_e;

  function automatic logic half_paused(input logic [HALF-1:0] s);
    int lows;
    lows = 0;
    for (int i = 0; i < HALF; i++) lows += (s[i] ? 0 : 1);
    return (lows >= 2);
  endfunction
endpackage

// File: rtl/miller_sync_find.sv
module miller_sync_find
  import miller_pkg::*;
(
  input  logic [WIN-1:0]   win,
  output logic             hit,
  output logic [POS_W-1:0] pos
);
  logic [BEAT-1:0] match;

  for (genvar k = 0; k < BEAT; k++) begin : g_off
    assign match[k] = ~win[k] & ~win[k+1] & (&win[k+BEAT-1:k+3]);
  end

  always_comb begin
    hit = |match;
    pos = '0;
    for (int k = BEAT - 1; k >= 0; k--) begin
      if (match[k]) pos = POS_W'(k);
    end
  end
endmodule

// File: rtl/miller_classify.sv
module miller_classify
  import miller_pkg::*;
(
  input  logic [WIN-1:0]   win,
  input  logic [POS_W-1:0] pos,
  output seq_e             seq
);
  logic [BEAT-1:0] period;
  logic            p_first, p_second;

  always_comb begin
    period   = win[pos +: BEAT];
    p_first  = half_paused(period[HALF-1:0]);
    p_second = half_paused(period[BEAT-1:HALF]);
    case ({p_first, p_second})
      2'b11:   seq = SEQ_BAD;
      2'b10:   seq = SEQ_Z;
      2'b01:   seq = SEQ_X;
      default: seq = SEQ_Y;
    endcase
  end
endmodule

// File: rtl/miller_out_reg.sv
module miller_out_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      dout  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      dout  <= din;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(dout)));
endmodule

// File: rtl/miller_frame_decoder.sv
module miller_frame_decoder
  import miller_pkg::*;
#(
  parameter int TS_W  = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [BEAT-1:0]  in_samples,
  output logic             byte_valid,
  input  logic             byte_ready,
  output logic [7:0]       byte_data,
  output logic             par_valid,
  input  logic             par_ready,
  output logic [PAR_W-1:0] par_data,
  output logic             frame_done,
  output logic [CNT_W-1:0] byte_count,
  output logic [TS_W-1:0]  start_ts,
  output logic [TS_W-1:0]  end_ts
);
  st_e               st_q, nst;
  logic [BEAT-1:0]   prev_q;
  logic [WIN-1:0]    win;
  logic [POS_W-1:0]  pos_q, spos;
  logic              hit;
  seq_e              seq;
  logic [CHAR_W-1:0] sh_q, sh_nx;
  logic [BIT_W-1:0]  bit_q;
  logic [PAR_W-1:0]  pacc_q, par_din;
  logic [PCNT_W-1:0] pcnt_q;
  logic [TS_W-1:0]   samp_q, start_q, end_q, nbits_q, ts_nx, soc_ts;
  logic [CNT_W-1:0]  bytes_q;
  logic go, push, pbit, err, eoc, clr, char_done, byte_load, par_full, flush, par_load;

  assign win = {in_samples, prev_q};

  miller_sync_find u_sync (.win(win), .hit(hit), .pos(spos));
  miller_classify  u_cls  (.win(win), .pos(pos_q), .seq(seq));

  assign in_ready = (~byte_valid | byte_ready) & (~par_valid | par_ready);
  assign go       = in_valid & in_ready;

  always_comb begin
    push = 1'b0; pbit = 1'b0; err = 1'b0; eoc = 1'b0; nst = st_q;
    if (st_q != ST_HUNT && st_q != ST_DONE) begin
      case (seq)
        SEQ_BAD: err = 1'b1;
        SEQ_Z: begin
          if (st_q == ST_X) err = 1'b1;
          else begin push = 1'b1; nst = ST_Z; end
        end
        SEQ_X: begin push = 1'b1; pbit = 1'b1; nst = ST_X; end
        default: begin
          if (st_q == ST_Z || st_q == ST_Y) eoc = 1'b1;
          else if (st_q == ST_SOC)          err = 1'b1;
          else begin push = 1'b1; nst = ST_Y; end
        end
      endcase
    end
  end

  assign clr       = (st_q == ST_HUNT && hit) || err || (eoc && bytes_q == '0);
  assign sh_nx     = {pbit, sh_q[CHAR_W-1:1]};
  assign char_done = push && (bit_q == BIT_W'(CHAR_W - 1));
  assign byte_load = go && char_done;
  assign par_full  = char_done && (pcnt_q == PCNT_W'(PAR_W - 1));
  assign flush     = eoc && (bytes_q != '0) && (pcnt_q != '0);
  assign par_load  = go && (par_full || flush);
  assign par_din   = par_full ? {pacc_q[PAR_W-2:0], pbit}
                              : (pacc_q << (PCNT_W + 1)'(PAR_W - int'(pcnt_q)));
  assign ts_nx     = start_q + ((nbits_q + TS_W'(1)) << 3) + (pbit ? TS_W'(6) : TS_W'(2));
  assign soc_ts    = samp_q - (TS_W'(BEAT) - TS_W'(spos));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_HUNT; prev_q <= '1; pos_q <= '0;
      samp_q <= '0; start_q <= '0; end_q <= '0;
      sh_q <= '0; bit_q <= '0; pacc_q <= '0; pcnt_q <= '0;
      nbits_q <= '0; bytes_q <= '0;
    end else if (go) begin
      prev_q <= in_samples;
      samp_q <= samp_q + TS_W'(BEAT);
      if (clr) begin
        sh_q <= '0; bit_q <= '0; pacc_q <= '0; pcnt_q <= '0;
        nbits_q <= '0; bytes_q <= '0;
      end else if (push) begin
        sh_q    <= sh_nx;
        nbits_q <= nbits_q + TS_W'(1);
        if (char_done) begin
          bit_q   <= '0;
          bytes_q <= bytes_q + CNT_W'(1);
          pacc_q  <= {pacc_q[PAR_W-2:0], pbit};
          pcnt_q  <= pcnt_q + PCNT_W'(1);
        end else begin
          bit_q <= bit_q + BIT_W'(1);
        end
        if (seq != SEQ_Y) end_q <= ts_nx;
      end
      if (st_q == ST_HUNT) begin
        if (hit) begin
          st_q <= ST_SOC; pos_q <= spos; start_q <= soc_ts; end_q <= soc_ts;
        end
      end else if (clr) st_q <= ST_HUNT;
      else if (eoc)     st_q <= ST_DONE;
      else if (push)    st_q <= nst;
    end
  end

  miller_out_reg #(.W(8)) u_byte_out (
    .clk(clk), .rst(rst), .load(byte_load), .din(sh_nx[7:0]),
    .ready(byte_ready), .valid(byte_valid), .dout(byte_data));

  miller_out_reg #(.W(PAR_W)) u_par_out (
    .clk(clk), .rst(rst), .load(par_load), .din(par_din),
    .ready(par_ready), .valid(par_valid), .dout(par_data));

  assign frame_done = (st_q == ST_DONE);
  assign byte_count = bytes_q;
  assign start_ts   = start_q;
  assign end_ts     = end_q;

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!byte_valid && !par_valid && byte_count == '0 && !frame_done));
  assert_full_blocks_input_R9: assert property (@(posedge clk) disable iff (rst)
    ((byte_valid && !byte_ready) || (par_valid && !par_ready)) |-> !in_ready);
  assert_z_after_x_R6: assert property (@(posedge clk) disable iff (rst)
    (go && st_q == ST_X && seq == SEQ_Z) |=> (byte_count == '0 && !frame_done));
  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> frame_done);
  assert_count_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> ($stable(byte_count) && $stable(start_ts)));
endmodule

// File: tb/miller_frame_decoder_tb_top.sv
module miller_frame_decoder_tb_top;
  localparam int TS_W = 32;
  localparam int CNT_W = 16;
  localparam logic [7:0] P_Z = 8'hFC, P_X = 8'hCF, P_Y = 8'hFF, P_BAD = 8'hCC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [7:0]       in_samples = 8'hFF;
  logic             byte_valid, par_valid, frame_done;
  logic             byte_ready = 1'b1;
  logic             par_ready = 1'b1;
  logic [7:0]       byte_data, par_data;
  logic [CNT_W-1:0] byte_count;
  logic [TS_W-1:0]  start_ts, end_ts;

  miller_frame_decoder #(.TS_W(TS_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_samples(in_samples), .byte_valid(byte_valid), .byte_ready(byte_ready),
    .byte_data(byte_data), .par_valid(par_valid), .par_ready(par_ready),
    .par_data(par_data), .frame_done(frame_done), .byte_count(byte_count),
    .start_ts(start_ts), .end_ts(end_ts));

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_b[$];
  logic [7:0] exp_p[$];
  bit sq[$];
  bit pbits[$];
  longint gsamp;
  longint m_start, m_end, m_n;
  int lk;  // 0: start/Z, 1: X, 2: Y
  bit bp_en = 0;
  bit alt = 0;
  bit track = 1;
  logic [15:0] lfsr = 16'hACE1;
  bit finished = 0;

  task automatic check(input string req, input longint act, input longint expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // monitor: picks readiness, then consumes the handshake of the coming edge
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    byte_ready = bp_en ? lfsr[0] : 1'b1;
    par_ready  = bp_en ? lfsr[5] : 1'b1;
    if (!rst && byte_valid && byte_ready) begin
      if (exp_b.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R10: actual unexpected byte %0d expected none", byte_data);
      end else check("R4 byte", byte_data, exp_b.pop_front());
    end
    if (!rst && par_valid && par_ready) begin
      if (exp_p.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R10: actual unexpected parity %0d expected none", par_data);
      end else check("R5 parity", par_data, exp_p.pop_front());
    end
  end

  task automatic add_period(input logic [7:0] p);
    for (int i = 0; i < 8; i++) sq.push_back(p[i]);
  endtask

  task automatic add_idle(input int n);
    for (int i = 0; i < n; i++) sq.push_back(1'b1);
  endtask

  task automatic drive_beat(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_samples = b;
    #2;
    while (!in_ready) begin
      @(negedge clk);
      #2;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    gsamp += 8;
  endtask

  task automatic send_stream();
    logic [7:0] b;
    add_idle(24);
    while (sq.size() % 8 != 0) sq.push_back(1'b1);
    while (sq.size() > 0) begin
      for (int i = 0; i < 8; i++) b[i] = sq.pop_front();
      drive_beat(b);
    end
    repeat (30) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    gsamp = 0;
    exp_b.delete();
    exp_p.delete();
  endtask

  task automatic begin_frame(input int s);
    add_idle(s);
    m_start = gsamp + sq.size();
    m_end = m_start;
    m_n = 0;
    lk = 0;
    pbits.delete();
    add_period(P_Z);
  endtask

  task automatic enc_bit(input bit b);
    m_n++;
    if (b) begin
      add_period(alt ? 8'h9F : P_X);
      m_end = m_start + 8 * m_n + 6;
      lk = 1;
    end else if (lk == 1) begin
      add_period(alt ? 8'hEF : P_Y);
      lk = 2;
    end else begin
      add_period(alt ? 8'hF9 : P_Z);
      m_end = m_start + 8 * m_n + 2;
      lk = 0;
    end
  endtask

  task automatic enc_byte(input logic [7:0] d);
    for (int i = 0; i < 8; i++) enc_bit(d[i]);
    enc_bit(~^d);
    if (track) begin
      exp_b.push_back(d);
      pbits.push_back(~^d);
    end
  endtask

  task automatic end_frame();
    logic [7:0] p;
    int k;
    enc_bit(1'b0);
    add_period(P_Y);
    if (track) begin
      k = 0;
      p = 8'h00;
      foreach (pbits[i]) begin
        p[7-k] = pbits[i];
        k++;
        if (k == 8) begin exp_p.push_back(p); p = 8'h00; k = 0; end
      end
      if (k != 0) exp_p.push_back(p);
    end
  endtask

  task automatic check_frame(input string req, input int nbytes);
    check({req, " frame_done"}, frame_done, 1);
    check({req, " byte_count"}, byte_count, nbytes);
    check("R3 start_ts", start_ts, m_start);
    check("R8 end_ts", end_ts, m_end);
    check("R9 all items delivered", exp_b.size() + exp_p.size(), 0);
  endtask

  task automatic check_abort(input string req);
    check({req, " frame_done"}, frame_done, 0);
    check({req, " byte_count"}, byte_count, 0);
    check("R9 all items delivered", exp_b.size() + exp_p.size(), 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    do_reset();
    @(negedge clk);
    check("R1 in_ready", in_ready, 1);
    check("R1 byte_valid", byte_valid, 0);
    check("R1 par_valid", par_valid, 0);
    check("R1 frame_done", frame_done, 0);
    check("R1 byte_count", byte_count, 0);

    // R4 R5 R7 R8: single byte, offset 3
    begin_frame(3); enc_byte(8'hA5); end_frame(); send_stream();
    check_frame("R7", 1);

    // R5 R9: ten bytes under back-pressure, offset 0
    do_reset(); bp_en = 1;
    begin_frame(0);
    for (int i = 0; i < 10; i++) enc_byte(8'(i * 37 + 11));
    end_frame(); send_stream();
    check_frame("R5", 10);
    bp_en = 0;

    // R2: alternative pause shapes, offset 7
    do_reset(); alt = 1;
    begin_frame(7); enc_byte(8'h00); enc_byte(8'hFF); enc_byte(8'h80);
    end_frame(); send_stream();
    alt = 0;
    check_frame("R2", 3);

    // R6: both halves paused, then a fresh frame without reset
    do_reset();
    begin_frame(5); enc_bit(0); enc_bit(1); add_period(P_BAD); send_stream();
    check_abort("R6 both halves");
    begin_frame(2); enc_byte(8'h3C); end_frame(); send_stream();
    check_frame("R6 resume", 1);

    // R6: Z right after X, after one byte already out
    do_reset();
    begin_frame(4); enc_byte(8'h96); enc_bit(1); add_period(P_Z); send_stream();
    check_abort("R6 z after x");

    // R6: Y right after start
    do_reset();
    begin_frame(1); add_period(P_Y); add_period(P_X); add_period(P_Z); send_stream();
    check_abort("R6 y after start");

    // R7: closing with no byte is silent, then a good frame
    do_reset();
    begin_frame(6); enc_bit(0); add_period(P_Y); send_stream();
    check_abort("R7 empty");
    begin_frame(1); enc_byte(8'h5A); end_frame(); send_stream();
    check_frame("R7 after empty", 1);

    // R10: another frame after done is ignored
    track = 0;
    begin
      longint s0, e0;
      s0 = m_start; e0 = m_end;
      begin_frame(2); enc_byte(8'h11); enc_byte(8'h22); end_frame(); send_stream();
      m_start = s0; m_end = e0;
    end
    track = 1;
    check_frame("R10", 1);

    summary();
  end
endmodule